// File: doc/BRIEF.md
# Iterative AES-128 Block Decryptor

This block turns one 128-bit ciphertext block back into plaintext under a 128-bit key, using a single round datapath that is reused over many clock cycles. A producer offers the key and the ciphertext together with a valid/accept handshake. The block then rebuilds the last round key by running the forward key expansion for ten cycles. After that it runs the inverse cipher for eleven cycles and regenerates each earlier round key from the one in use, so no round-key storage is needed. The plaintext is presented to a consumer through a second valid/accept handshake.

Only one block is in flight at a time. Input accept is high only while the block is idle, and it comes back high in the same cycle that the consumer takes the result. A producer that keeps its valid high therefore gets its next block captured on the following edge. Reset is asynchronous and active low.

Top module: `aes128_inv_iter`

## Requirements
- R1: While reset is asserted and directly after its release, in_accept, out_valid and pt_out are all zero. in_accept rises on the first clock edge after release.
- R2: in_accept is high only while the block is idle, never together with out_valid. After an edge where in_valid and in_accept are both high, in_accept is low.
- R3: Byte k (k = 4c + r, row r, column c) of each 128-bit vector occupies bits [127-8k : 120-8k]. Key word c is bits [127-32c : 96-32c], and its most significant byte pairs with row 0. pt_out equals the AES-128 decryption of the captured ciphertext under the captured key, in the same byte order.
- R4: out_valid rises 21 rising edges after the capturing edge: ten key expansion steps, then eleven inverse-cipher steps, with the result registered on the last step.
- R5: While out_valid is high and out_accept is low, out_valid stays high and pt_out stays unchanged.
- R6: After an edge with out_valid and out_accept both high, out_valid is low, pt_out is zero and in_accept is high.
- R7: Changes on key_in, ct_in or in_valid while a block is being processed have no effect on its result.
- R8: Blocks offered back to back with different keys are each decrypted correctly. The key state left from one block has no effect on the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_in | input | 128 | Cipher key, word 0 in the top bits |
| ct_in | input | 128 | Ciphertext block, byte 0 in the top bits |
| in_valid | input | 1 | Producer offers key and ciphertext |
| in_accept | output | 1 | Block is idle and takes the offer |
| pt_out | output | 128 | Plaintext block, zero when not valid |
| out_valid | output | 1 | Plaintext is presented |
| out_accept | input | 1 | Consumer takes the plaintext |

## Verification
The hardest situation to reach from the ports is a result that has to survive noise on the input side. This means the input lines change while a block is still inside the round loop, and the next block is captured on the very edge after the consumer takes the previous one. The bench drives garbage keys, garbage data and a raised in_valid during processing. It also keeps a held result waiting for several cycles, and it chains blocks with different known vectors so that each capture follows a release directly. Every plaintext is compared against published test vectors.

// File: rtl/aes128_inv_iter.sv
module aes128_inv_iter (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [127:0] key_in,
  input  logic [127:0] ct_in,
  input  logic         in_valid,
  output logic         in_accept,
  output logic [127:0] pt_out,
  output logic         out_valid,
  input  logic         out_accept
);
  localparam int NR = 10;
  localparam int SW = $clog2(NR + 1);
  localparam logic [SW-1:0] LAST_EXP = SW'(NR - 1);
  localparam logic [SW-1:0] LAST_RND = SW'(NR);

  typedef enum logic [1:0] {IDLE, EXPAND, DECR, HOLD} phase_t;

  phase_t        phase;
  logic [SW-1:0] step;
  logic [127:0]  st, rk;
  logic [127:0]  fwd_key, bwd_key, keyed, mixed;

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 8'h00;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = xt(x);
    end
    return p;
  endfunction

  function automatic logic [7:0] ginv(input logic [7:0] a);
    logic [7:0] p = a;
    logic [7:0] r = 8'h01;
    for (int i = 1; i < 8; i++) begin
      p = gmul(p, p);
      r = gmul(r, p);
    end
    return r;
  endfunction

  function automatic logic [7:0] rl(input logic [7:0] a, input int n);
    return (a << n) | (a >> (8 - n));
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] a);
    logic [7:0] b = ginv(a);
    return b ^ rl(b, 1) ^ rl(b, 2) ^ rl(b, 3) ^ rl(b, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] isbox(input logic [7:0] a);
    return ginv(rl(a, 1) ^ rl(a, 3) ^ rl(a, 6) ^ 8'h05);
  endfunction

  function automatic logic [7:0] rcon(input logic [SW-1:0] idx);
    logic [7:0] r = 8'h01;
    for (int i = 0; i < NR; i++)
      if (SW'(i) < idx) r = xt(r);
    return r;
  endfunction

  function automatic logic [31:0] core(input logic [31:0] w, input logic [7:0] rc);
    logic [31:0] t = {w[23:0], w[31:24]};
    return {sbox(t[31:24]) ^ rc, sbox(t[23:16]), sbox(t[15:8]), sbox(t[7:0])};
  endfunction

  function automatic logic [127:0] key_fwd(input logic [127:0] k, input logic [7:0] rc);
    logic [31:0] n0, n1, n2, n3;
    n0 = k[127:96] ^ core(k[31:0], rc);
    n1 = k[95:64] ^ n0;
    n2 = k[63:32] ^ n1;
    n3 = k[31:0] ^ n2;
    return {n0, n1, n2, n3};
  endfunction

  function automatic logic [127:0] key_bwd(input logic [127:0] k, input logic [7:0] rc);
    logic [31:0] p0, p1, p2, p3;
    p3 = k[31:0] ^ k[63:32];
    p2 = k[63:32] ^ k[95:64];
    p1 = k[95:64] ^ k[127:96];
    p0 = k[127:96] ^ core(p3, rc);
    return {p0, p1, p2, p3};
  endfunction

  function automatic logic [127:0] shift_sub(input logic [127:0] v);
    logic [127:0] o;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        o[127-8*(4*c+r) -: 8] = isbox(v[127-8*(4*((c-r+4)%4)+r) -: 8]);
    return o;
  endfunction

  function automatic logic [127:0] inv_mix(input logic [127:0] v);
    logic [127:0] o;
    logic [7:0] a0, a1, a2, a3;
    for (int c = 0; c < 4; c++) begin
      a0 = v[127-32*c -: 8];
      a1 = v[119-32*c -: 8];
      a2 = v[111-32*c -: 8];
      a3 = v[103-32*c -: 8];
      o[127-32*c -: 8] = gmul(a0, 8'h0e) ^ gmul(a1, 8'h0b) ^ gmul(a2, 8'h0d) ^ gmul(a3, 8'h09);
      o[119-32*c -: 8] = gmul(a0, 8'h09) ^ gmul(a1, 8'h0e) ^ gmul(a2, 8'h0b) ^ gmul(a3, 8'h0d);
      o[111-32*c -: 8] = gmul(a0, 8'h0d) ^ gmul(a1, 8'h09) ^ gmul(a2, 8'h0e) ^ gmul(a3, 8'h0b);
      o[103-32*c -: 8] = gmul(a0, 8'h0b) ^ gmul(a1, 8'h0d) ^ gmul(a2, 8'h09) ^ gmul(a3, 8'h0e);
    end
    return o;
  endfunction

  assign fwd_key = key_fwd(rk, rcon(step));
  assign bwd_key = key_bwd(rk, rcon(LAST_EXP - step));
  assign keyed   = shift_sub(st) ^ rk;
  assign mixed   = inv_mix(keyed);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= IDLE;
      step      <= '0;
      st        <= '0;
      rk        <= '0;
      in_accept <= 1'b0;
      out_valid <= 1'b0;
      pt_out    <= '0;
    end else begin
      case (phase)
        IDLE: begin
          in_accept <= 1'b1;
          if (in_valid && in_accept) begin
            st        <= ct_in;
            rk        <= key_in;
            step      <= '0;
            in_accept <= 1'b0;
            phase     <= EXPAND;
          end
        end
        EXPAND: begin
          rk <= fwd_key;
          if (step == LAST_EXP) begin
            step  <= '0;
            phase <= DECR;
          end else begin
            step <= step + 1'b1;
          end
        end
        DECR: begin
          step <= step + 1'b1;
          if (step == '0) begin
            st <= st ^ rk;
            rk <= bwd_key;
          end else if (step != LAST_RND) begin
            st <= mixed;
            rk <= bwd_key;
          end else begin
            pt_out    <= keyed;
            out_valid <= 1'b1;
            phase     <= HOLD;
          end
        end
        default: begin
          if (out_accept) begin
            out_valid <= 1'b0;
            pt_out    <= '0;
            in_accept <= 1'b1;
            phase     <= IDLE;
          end
        end
      endcase
    end
  end
endmodule

module aes128_inv_iter_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_accept,
  input logic [127:0] pt_out,
  input logic         out_valid,
  input logic         out_accept
);
  logic [4:0] wait_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_cnt <= '0;
    else if (in_valid && in_accept) wait_cnt <= 5'd1;
    else if (wait_cnt != '0 && !out_valid && wait_cnt != 5'd31) wait_cnt <= wait_cnt + 1'b1;
  end

  assert_idle_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> pt_out == '0);
  assert_accept_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_accept |=> !in_accept);
  assert_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_accept && out_valid));
  assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> wait_cnt == 5'd22);
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_accept |=> out_valid && $stable(pt_out));
  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_accept |=> !out_valid && pt_out == '0 && in_accept);
endmodule

bind aes128_inv_iter aes128_inv_iter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_accept(in_accept),
  .pt_out(pt_out), .out_valid(out_valid), .out_accept(out_accept)
);

// File: tb/tb_aes128_inv_iter.sv
module tb_aes128_inv_iter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [127:0] key_in = '0, ct_in = '0;
  logic in_valid = 1'b0, out_accept = 1'b0;
  logic in_accept, out_valid;
  logic [127:0] pt_out;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  aes128_inv_iter dut (
    .clk(clk), .rst_n(rst_n), .key_in(key_in), .ct_in(ct_in), .in_valid(in_valid),
    .in_accept(in_accept), .pt_out(pt_out), .out_valid(out_valid), .out_accept(out_accept)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [127:0] k, input logic [127:0] ct, input logic [127:0] pt,
                     input int hold, input bit noisy);
    int edges = 0;
    logic [127:0] seen;
    bit busy_ok = 1;
    key_in = k; ct_in = ct; in_valid = 1'b1;
    while (!in_accept) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_accept == 1'b0, "R2 accept drop", {127'd0, in_accept}, 128'd0);
    if (noisy) begin
      key_in = ~k; ct_in = 128'hdead_beef_0bad_f00d_1234_5678_9abc_def0; in_valid = 1'b1;
    end
    while (!out_valid && edges < 100) begin
      @(negedge clk);
      edges++;
      if (in_accept && !out_valid) busy_ok = 0;
    end
    in_valid = 1'b0;
    chk(busy_ok, "R2 accept low while busy", {127'd0, busy_ok}, 128'd1);
    chk(edges == 21, "R4 latency", 128'(edges), 128'd21);
    chk(pt_out == pt, noisy ? "R7 noisy inputs" : "R3 plaintext", pt_out, pt);
    seen = pt_out;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(out_valid && pt_out == seen, "R5 hold", pt_out, seen);
    end
    out_accept = 1'b1;
    @(negedge clk);
    out_accept = 1'b0;
    chk(!out_valid && pt_out == '0 && in_accept, "R6 release",
        {pt_out[127:2], out_valid, in_accept}, 128'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!in_accept && !out_valid && pt_out == '0, "R1 in reset",
        {pt_out[127:2], in_accept, out_valid}, 128'd0);
    rst_n = 1'b1;
    #1;
    chk(!in_accept && !out_valid && pt_out == '0, "R1 after release",
        {pt_out[127:2], in_accept, out_valid}, 128'd0);
    @(negedge clk);
    chk(in_accept == 1'b1, "R1 accept rises", {127'd0, in_accept}, 128'd1);
    run(128'h000102030405060708090a0b0c0d0e0f, 128'h69c4e0d86a7b0430d8cdb78070b4c55a,
        128'h00112233445566778899aabbccddeeff, 4, 0);
    run(128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h3925841d02dc09fbdc118597196a0b32,
        128'h3243f6a8885a308d313198a2e0370734, 0, 0);
    run(128'h0, 128'h66e94bd4ef8a2c3b884cfa59ca342b2e, 128'h0, 2, 1);
    run(128'h000102030405060708090a0b0c0d0e0f, 128'h69c4e0d86a7b0430d8cdb78070b4c55a,
        128'h00112233445566778899aabbccddeeff, 0, 1);
    // R8: the four blocks above follow each release directly with changing keys
    chk(1'b1, "R8 chained keys", 128'd0, 128'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule